// File: doc/BRIEF.md
# Two-Stage Selective Tag Comparator

This block resolves the tag lookup for one set of a set-associative cache so that few tag bits are sensed on each access. When a request is presented, a narrow low-order slice of every way's stored tag is read and compared with the same slice of the request tag. Only the ways that pass this filter, and that hold a valid line, get their wide high-order slice enabled and compared. Most ways therefore never have their upper bits sensed, yet the hit decision is exactly what a full-width parallel comparison would give. There is no guessing and no retry.

The surrounding cache drives the request tag and a strobe, and presents the stored tags and valid bits of the indexed set in the same cycle. In that cycle the block drives per-way read enables for the low slice and for the high slice to the tag array. The registered result is available on the next cycle: a hit flag, a one-hot hit way, a multi-hit error flag and the number of tag bits sensed. A small controller with two states, `ST_IDLE` and `ST_RESP`, sequences this. The transition `ST_IDLE -> ST_RESP` and the self-loop `ST_RESP -> ST_RESP` are taken when a request is present. `ST_RESP -> ST_IDLE` and `ST_IDLE -> ST_IDLE` are taken when no request is present. Reads and writes go through the same filter.

Top module: `sel_tag_lookup`

## Requirements
- R1: In a cycle with `req_valid` high, every bit of `lo_rd_en` is 1. In a cycle with `req_valid` low, `lo_rd_en` and `hi_rd_en` are all 0.
- R2: In a request cycle, `hi_rd_en[w]` is 1 exactly when `way_valid[w]` is 1 and bits [LO_W-1:0] of way w's tag (LO_W = 4 by default) equal bits [LO_W-1:0] of `req_tag`.
- R3: One cycle after a request, `hit` is 1 exactly when some valid way's full 31-bit tag equals the request tag.
- R4: One cycle after a request, `hit_way` is one-hot on the lowest-numbered valid fully-matching way, and is all zero on a miss.
- R5: One cycle after a request, `multi_hit` is 1 exactly when two or more valid ways fully match the request tag.
- R6: One cycle after a request, `bit_reads` equals 4 × WAYS + 27 × (number of ways that had `hi_rd_en` set), which never exceeds 31 × WAYS.
- R7: `rsp_valid` is 1 exactly one cycle after each cycle with `req_valid` high. While `rsp_valid` is 0, `hit`, `hit_way`, `multi_hit` and `bit_reads` are all 0.
- R8: During reset and in the first cycle after it, all registered outputs are 0.
- R9: Back-to-back requests each give a result that depends only on their own inputs. No survivor state carries over from the previous request.
- R10: A way whose high-order bits match the request but whose low-order slice differs never sets `hit` and never gets `hi_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, read or write |
| req_tag | input | 31 | Request tag |
| way_tags | input | 496 | Stored tags of the set, way w at bits [31w+30:31w] |
| way_valid | input | 16 | Per-way valid bits |
| lo_rd_en | output | 16 | Per-way low-slice read enable |
| hi_rd_en | output | 16 | Per-way high-slice read enable |
| rsp_valid | output | 1 | Result valid |
| hit | output | 1 | Request hit |
| hit_way | output | 16 | One-hot hit way |
| multi_hit | output | 1 | More than one way matched |
| bit_reads | output | 9 | Tag bits sensed for the access |

## Verification
Random sets are built so that each way is, at random, invalid, a full match, a low-slice-only match, a high-slice-only match or unrelated. This separates filter survivors from true hits and shows whether invalid ways leak into the high-slice enables. Directed sets cover the extremes. An all-invalid set gives the minimum bit count. A set where every way passes the filter but none hits gives the maximum count and a miss. Sets where all ways hit, or only the top way hits, test the lowest-index priority and the multi-hit flag. Requests run back to back and with idle gaps between them, which checks that results do not carry over and that idle outputs stay quiet.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int TAG_W_DEF = 31;
    localparam int LO_W_DEF  = 4;
    localparam int WAYS_DEF  = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } stc_state_e;
endpackage

// File: rtl/stc_way_slice.sv
module stc_way_slice #(
    parameter int TAG_W = 31,
    parameter int LO_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_phase,
    input  logic             hi_phase,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] way_tag,
    input  logic             way_vld,
    output logic             lo_rd_en,
    output logic             hi_rd_en,
    output logic             full_match
);
    localparam int HI_W = TAG_W - LO_W;

    logic [LO_W-1:0] lo_sensed;
    logic [HI_W-1:0] hi_sensed;
    logic            survive;

    // Low slice is sensed for every way during the filter phase.
    assign lo_rd_en  = lo_phase;
    assign lo_sensed = lo_rd_en ? way_tag[LO_W-1:0] : '0;

    // Survivor flag: set by a low-slice match of a valid way, cleared otherwise
    // (a fresh decision each request, nothing is held across requests).
    assign survive = lo_rd_en && way_vld && (lo_sensed == req_tag[LO_W-1:0]);

    // High slice read enable: survivor AND stage-two phase.
    assign hi_rd_en   = survive && hi_phase;
    assign hi_sensed  = hi_rd_en ? way_tag[TAG_W-1:LO_W] : '0;
    assign full_match = hi_rd_en && (hi_sensed == req_tag[TAG_W-1:LO_W]);

    AST_HI_NEEDS_LO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd_en |-> (way_tag[LO_W-1:0] == req_tag[LO_W-1:0])); // R10
    AST_MATCH_IS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full_match |-> (way_tag == req_tag) && way_vld); // R3
endmodule

// File: rtl/stc_resolve.sv
module stc_resolve #(
    parameter int WAYS  = 16,
    parameter int TAG_W = 31,
    parameter int LO_W  = 4,
    parameter int CNT_W = 9
) (
    input  logic [WAYS-1:0]  match_vec,
    input  logic [WAYS-1:0]  survive_vec,
    output logic [WAYS-1:0]  first_hit,
    output logic             any_hit,
    output logic             many_hit,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam int HI_W  = TAG_W - LO_W;
    localparam int SUR_W = $clog2(WAYS + 1);
    localparam logic [CNT_W-1:0] BASE_BITS = CNT_W'(LO_W * WAYS);
    localparam logic [CNT_W-1:0] HI_BITS   = CNT_W'(HI_W);

    logic [SUR_W-1:0] sur_cnt;
    logic [SUR_W-1:0] hit_cnt;

    // Lowest index wins.
    always_comb begin
        first_hit = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_vec[w]) begin
                first_hit    = '0;
                first_hit[w] = 1'b1;
            end
        end
    end

    always_comb begin
        sur_cnt = '0;
        hit_cnt = '0;
        for (int w = 0; w < WAYS; w++) begin
            sur_cnt = sur_cnt + SUR_W'(survive_vec[w]);
            hit_cnt = hit_cnt + SUR_W'(match_vec[w]);
        end
    end

    assign any_hit  = |match_vec;
    assign many_hit = (hit_cnt > SUR_W'(1));
    assign bit_cnt  = BASE_BITS + HI_BITS * CNT_W'(sur_cnt);
endmodule

// File: rtl/stc_ctrl.sv
module stc_ctrl
    import stc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic lo_phase,
    output logic hi_phase,
    output logic capture,
    output logic rsp_valid
);
    stc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        lo_phase  = 1'b0;
        hi_phase  = 1'b0;
        capture   = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
                state_d   = req_valid ? ST_RESP : ST_IDLE;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                state_d   = req_valid ? ST_RESP : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        // Filter phase then high phase, both inside the request cycle.
        lo_phase = req_valid;
        hi_phase = req_valid;
        capture  = req_valid;
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R7
    AST_RSP_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R7
endmodule

// File: rtl/sel_tag_lookup.sv
module sel_tag_lookup
    import stc_pkg::*;
#(
    parameter int WAYS  = WAYS_DEF,
    parameter int TAG_W = TAG_W_DEF,
    parameter int LO_W  = LO_W_DEF,
    parameter int CNT_W = $clog2(WAYS * TAG_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [TAG_W-1:0]      req_tag,
    input  logic [WAYS*TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]       way_valid,
    output logic [WAYS-1:0]       lo_rd_en,
    output logic [WAYS-1:0]       hi_rd_en,
    output logic                  rsp_valid,
    output logic                  hit,
    output logic [WAYS-1:0]       hit_way,
    output logic                  multi_hit,
    output logic [CNT_W-1:0]      bit_reads
);
    localparam logic [CNT_W-1:0] MAX_BITS = CNT_W'(WAYS * TAG_W);
    localparam logic [CNT_W-1:0] MIN_BITS = CNT_W'(WAYS * LO_W);

    logic             lo_phase, hi_phase, capture;
    logic [WAYS-1:0]  match_vec;
    logic [WAYS-1:0]  first_hit;
    logic             any_hit, many_hit;
    logic [CNT_W-1:0] bit_cnt;

    stc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .lo_phase  (lo_phase),
        .hi_phase  (hi_phase),
        .capture   (capture),
        .rsp_valid (rsp_valid)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        stc_way_slice #(.TAG_W(TAG_W), .LO_W(LO_W)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .lo_phase   (lo_phase),
            .hi_phase   (hi_phase),
            .req_tag    (req_tag),
            .way_tag    (way_tags[w*TAG_W +: TAG_W]),
            .way_vld    (way_valid[w]),
            .lo_rd_en   (lo_rd_en[w]),
            .hi_rd_en   (hi_rd_en[w]),
            .full_match (match_vec[w])
        );
    end

    stc_resolve #(.WAYS(WAYS), .TAG_W(TAG_W), .LO_W(LO_W), .CNT_W(CNT_W)) u_resolve (
        .match_vec   (match_vec),
        .survive_vec (hi_rd_en),
        .first_hit   (first_hit),
        .any_hit     (any_hit),
        .many_hit    (many_hit),
        .bit_cnt     (bit_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || !capture) begin
            hit       <= 1'b0;
            hit_way   <= '0;
            multi_hit <= 1'b0;
            bit_reads <= '0;
        end else begin
            hit       <= any_hit;
            hit_way   <= first_hit;
            multi_hit <= many_hit;
            bit_reads <= bit_cnt;
        end
    end

    AST_IDLE_NO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (lo_rd_en == '0) && (hi_rd_en == '0)); // R1
    AST_ALL_LO_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (lo_rd_en == {WAYS{1'b1}})); // R1
    AST_HI_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd_en & ~way_valid) == '0); // R2
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $onehot0(hit_way) && (hit_way != '0)); // R4
    AST_MISS_NO_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_way == '0)); // R4
    AST_MULTI_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> hit); // R5
    AST_BITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (bit_reads >= MIN_BITS) && (bit_reads <= MAX_BITS)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !hit && !multi_hit && (bit_reads == '0)); // R7
endmodule

// File: tb/tb_sel_tag_lookup.sv
module tb_sel_tag_lookup;
    localparam int WAYS  = 16;
    localparam int TAG_W = 31;
    localparam int LO_W  = 4;
    localparam int CNT_W = 9;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic [TAG_W-1:0]      req_tag = '0;
    logic [WAYS*TAG_W-1:0] way_tags = '0;
    logic [WAYS-1:0]       way_valid = '0;
    logic [WAYS-1:0]       lo_rd_en, hi_rd_en, hit_way;
    logic                  rsp_valid, hit, multi_hit;
    logic [CNT_W-1:0]      bit_reads;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // expected values of the access in flight
    logic            e_hit, e_multi;
    logic [WAYS-1:0] e_way, e_hi;
    int              e_bits;

    always #2.5 clk = ~clk;

    sel_tag_lookup dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .way_tags(way_tags), .way_valid(way_valid), .lo_rd_en(lo_rd_en),
        .hi_rd_en(hi_rd_en), .rsp_valid(rsp_valid), .hit(hit), .hit_way(hit_way),
        .multi_hit(multi_hit), .bit_reads(bit_reads)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [TAG_W-1:0] tag_of(int w);
        return way_tags[w*TAG_W +: TAG_W];
    endfunction

    task automatic compute_exp();
        int nh = 0;
        int ns = 0;
        e_hi = '0; e_way = '0; e_hit = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_valid[w] && tag_of(w)[LO_W-1:0] == req_tag[LO_W-1:0]) begin
                e_hi[w] = 1'b1; ns++;
            end
            if (way_valid[w] && tag_of(w) == req_tag) begin
                if (!e_hit) e_way[w] = 1'b1;
                e_hit = 1'b1; nh++;
            end
        end
        e_multi = (nh > 1);
        e_bits  = LO_W * WAYS + (TAG_W - LO_W) * ns;
    endtask

    // Drive at negedge, check enables, then check registered result one negedge later.
    task automatic access(logic [TAG_W-1:0] t, bit last);
        req_valid = 1'b1;
        req_tag   = t;
        compute_exp();
        #1;
        chk("R1 lo_rd_en", 32'(lo_rd_en), 32'hFFFF);
        chk("R2/R10 hi_rd_en", 32'(hi_rd_en), 32'(e_hi));
        @(negedge clk);
        chk("R7 rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R3 hit", 32'(hit), 32'(e_hit));
        chk("R4 hit_way", 32'(hit_way), 32'(e_way));
        chk("R5 multi_hit", 32'(multi_hit), 32'(e_multi));
        chk("R6 bit_reads", 32'(bit_reads), 32'(e_bits));
        if (last) req_valid = 1'b0;
    endtask

    task automatic idle_check();
        #1;
        chk("R1 idle enables", 32'({lo_rd_en, hi_rd_en}), 32'd0);
        @(negedge clk);
        chk("R7 idle rsp", 32'({rsp_valid, hit, multi_hit}), 32'd0);
        chk("R7 idle outputs", 32'(bit_reads) | 32'(hit_way), 32'd0);
    endtask

    // Fill the set: kind per way 0 invalid, 1 full match, 2 low only, 3 high only, 4 random
    task automatic random_set(logic [TAG_W-1:0] t, int pct_hit);
        for (int w = 0; w < WAYS; w++) begin
            int k = int'($urandom_range(99));
            logic [TAG_W-1:0] v = TAG_W'($urandom);
            int kind = (k < pct_hit) ? 1 : 1 + int'($urandom_range(4)) % 5;
            if (kind == 5) kind = 0;
            way_valid[w] = (kind != 0) || ($urandom_range(1) == 1);
            case (kind)
                1: v = t;
                2: begin v[LO_W-1:0] = t[LO_W-1:0]; if (v == t) v[TAG_W-1] = ~v[TAG_W-1]; end
                3: begin v = t; v[0] = ~v[0]; end
                default: ;
            endcase
            way_tags[w*TAG_W +: TAG_W] = v;
        end
    endtask

    initial begin
        #50000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [TAG_W-1:0] t;
        void'($urandom(32'd20240611));
        @(negedge clk);
        chk("R8 reset rsp", 32'({rsp_valid, hit, multi_hit}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 after reset", 32'(bit_reads) | 32'(hit_way) | 32'(rsp_valid), 32'd0);

        // all ways invalid: minimum bit count, miss
        t = 31'h1234_5675;
        for (int w = 0; w < WAYS; w++) way_tags[w*TAG_W +: TAG_W] = t;
        way_valid = '0;
        access(t, 1'b1);
        idle_check();

        // all valid, all match: multi-hit, way 0 reported
        way_valid = '1;
        access(t, 1'b1);

        // only the top way matches
        for (int w = 0; w < WAYS - 1; w++) way_tags[w*TAG_W +: TAG_W] = t ^ 31'h10;
        access(t, 1'b1);

        // R10: every way passes the filter but high bits differ -> max reads, miss
        for (int w = 0; w < WAYS; w++) way_tags[w*TAG_W +: TAG_W] = t ^ 31'h4000_0000;
        access(t, 1'b1);

        // R10: high bits match, low slice differs -> no high reads, miss
        for (int w = 0; w < WAYS; w++) way_tags[w*TAG_W +: TAG_W] = t ^ 31'h1;
        access(t, 1'b1);
        idle_check();

        // R9: random back-to-back requests with occasional idle gaps
        for (int i = 0; i < 400; i++) begin
            t = TAG_W'($urandom);
            random_set(t, (i % 3 == 0) ? 5 : 25);
            access(t, (i % 7 == 6));
            if (i % 7 == 6) idle_check();
        end
        req_valid = 1'b0;
        idle_check();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule